// File: doc/BRIEF.md
# Local-Bus Command Sequencer

This block turns the two active-low status lines of a processor into a complete local-bus cycle. The processor starts a cycle by pulling one of the status lines low. The block then walks the bus through its status and command states and stretches the command state with wait states until the ready input goes low. It drives one of four active-low strobes: memory read, memory write, I/O read or I/O write. It also drives a data-enable output and a data-direction output for the data-bus transceivers.

A separately sampled command-hold input can keep the strobe off for as long as it is high. Ready can still end the cycle while the strobe is held off. In that case no strobe is ever issued, yet the data-bus controls return to their idle levels exactly as in a normal cycle. A mode strap selects the command timing. With the strap at 0 the strobe may fire at the first command clock. With the strap at 1 it waits at least one command clock. All sampling happens on the rising edge of `clk`. One bus state spans two clocks, and the first clock of the status state is the idle clock in which the status is sampled.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: While rst_n is low and after reset, all four strobes are high, den is 0 and dt_r is 1. With {s1_n,s0_n}=11 sampled, the block stays idle and these levels hold.
- R2: A cycle starts at an edge where {s1_n,s0_n} is not 11 and the block is idle or is ending a cycle. At every other edge the status lines have no effect.
- R3: Status 01 means read and 10 means write. Status 00 runs a cycle that issues no strobe and no den. io_sel=1 selects the I/O strobes and io_sel=0 the memory strobes, and io_sel is latched at the start edge only.
- R4: The status state lasts one clock after the start edge, followed by a command state of two clocks. ready_n is sampled at the last edge of each command state. When it is high, the command state repeats as a wait state.
- R5: For a read, dt_r is 0 from the clock after the start edge until the ending edge. For writes, for status 00 and in idle, dt_r is 1.
- R6: With strap_mb=0, the strobe and den assert at the first edge, from the one ending the status state onward, at which cmd_hold is sampled low. den is 1 exactly while a strobe is low.
- R7: With strap_mb=1, the strobe is not asserted at the edge ending the status state. It asserts at the first later in-cycle edge at which cmd_hold has been sampled low. The earliest such edge is the one entering the second command clock.
- R8: Once a strobe is active, the strobes, den and dt_r do not change through wait states until the ending edge.
- R9: At the edge where ready_n is sampled low, all strobes go high and den goes to 0. This holds even when cmd_hold kept the strobe off for the whole cycle, in which case no strobe pulse occurs at all. dt_r returns to 1 unless a new read starts at that edge.
- R10: If status is active at the ending edge, the next cycle's status state follows at once, with no idle clock.
- R11: At most one strobe is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| s1_n | input | 1 | Status line 1, active low |
| s0_n | input | 1 | Status line 0, active low |
| io_sel | input | 1 | 1 = I/O space, 0 = memory space, latched at cycle start |
| ready_n | input | 1 | Active-low cycle end, sampled at end of each command state |
| cmd_hold | input | 1 | High holds the strobe off |
| strap_mb | input | 1 | Command timing mode strap |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| den | output | 1 | Data enable, active high |
| dt_r | output | 1 | Data direction, 0 = toward the processor (read) |

## Verification
Some rules hold on every cycle, and the assertions watch them continuously:
- the fixed progression from status to command states and the wait-state loop;
- at most one strobe at a time, with den tracking the strobe;
- read direction for the length of the cycle;
- frozen outputs while a strobe is active;
- the release at the ending edge;
- the mode-1 hold-off at the status-to-command edge;
- the jump straight into a new status state.

Only the bench's scenarios can show the exact clock on which the strobe appears for a given cmd_hold length and wait count. The same holds for these cases:
- an early end with no strobe;
- strobe selection from a latched io_sel that later changes;
- status 00 cycles;
- status ignored mid-cycle;
- reset in the middle of a cycle.

// File: rtl/buscmd_pkg.sv
// Shared types and constants for the local-bus command sequencer.
// Assumes the status pair is presented as {s1_n, s0_n}.
package buscmd_pkg;
    localparam int STAT_W   = 2;
    localparam int N_STROBE = 4;
    localparam int SEL_W    = $clog2(N_STROBE);

    localparam logic [STAT_W-1:0] STAT_NONE = 2'b11;
    localparam logic [STAT_W-1:0] STAT_RD   = 2'b01;
    localparam logic [STAT_W-1:0] STAT_WR   = 2'b10;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STAT = 2'd1,
        PH_CMD1 = 2'd2,
        PH_CMD2 = 2'd3
    } bus_ph_t;

    typedef enum logic [1:0] {
        CY_NONE  = 2'd0,
        CY_READ  = 2'd1,
        CY_WRITE = 2'd2
    } cyc_kind_t;

    // Map a status code to the kind of cycle it starts.
    function automatic cyc_kind_t decode_stat(input logic [STAT_W-1:0] s);
        case (s)
            STAT_RD: decode_stat = CY_READ;
            STAT_WR: decode_stat = CY_WRITE;
            default: decode_stat = CY_NONE;
        endcase
    endfunction
endpackage

// File: rtl/buscmd_seq.sv
// Bus state sequencer: tracks idle, status and the two clocks of each
// command state, latches cycle kind and space at the start edge, and
// flags the start and ending edges. Assumes ready_n is synchronous.
module buscmd_seq
    import buscmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_n,
    input  logic              io_sel,
    input  logic              ready_n,
    output bus_ph_t           phase,
    output cyc_kind_t         kind,
    output cyc_kind_t         kind_nxt,
    output logic              is_io,
    output logic              start,
    output logic              finish
);
    bus_ph_t phase_nxt;

    // Edge qualifiers: cycle end and cycle start for this edge.
    always_comb begin
        finish   = (phase == PH_CMD2) && !ready_n;
        start    = ((phase == PH_IDLE) || finish) && (stat_n != STAT_NONE);
        kind_nxt = start ? decode_stat(stat_n) : kind;
    end

    // Next bus phase.
    always_comb begin
        case (phase)
            PH_IDLE: phase_nxt = start ? PH_STAT : PH_IDLE;
            PH_STAT: phase_nxt = PH_CMD1;
            PH_CMD1: phase_nxt = PH_CMD2;
            default: phase_nxt = !ready_n ? (start ? PH_STAT : PH_IDLE) : PH_CMD1;
        endcase
    end

    // Phase register and per-cycle latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            kind  <= CY_NONE;
            is_io <= 1'b0;
        end else begin
            phase <= phase_nxt;
            kind  <= kind_nxt;
            if (start) is_io <= io_sel;
        end
    end
endmodule

// File: rtl/buscmd_gate.sv
// Command release gate: samples cmd_hold from the edge ending the status
// state onward, remembers the release for the rest of the cycle, and
// applies the mode-1 hold-off at the status-to-command edge.
module buscmd_gate
    import buscmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  bus_ph_t phase,
    input  logic    start,
    input  logic    finish,
    input  logic    cmd_hold,
    input  logic    strap_mb,
    output logic    go_nxt
);
    logic released;
    logic in_cyc;
    logic rel_nxt;

    // Release decision for the clock after this edge.
    always_comb begin
        in_cyc  = (phase != PH_IDLE) && !finish;
        rel_nxt = !start && in_cyc && (released || !cmd_hold);
        go_nxt  = rel_nxt && !(strap_mb && (phase == PH_STAT));
    end

    // Sticky release flag, cleared at every cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) released <= 1'b0;
        else        released <= rel_nxt;
    end
endmodule

// File: rtl/buscmd_drv.sv
// Output drivers: one registered active-low strobe per command, data
// enable with the strobe, and direction set at the start edge and
// released at the ending edge.
module buscmd_drv
    import buscmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go_nxt,
    input  logic                start,
    input  logic                finish,
    input  cyc_kind_t           kind,
    input  cyc_kind_t           kind_nxt,
    input  logic                is_io,
    output logic [N_STROBE-1:0] strb_n,
    output logic                den,
    output logic                dt_r
);
    logic             live;
    logic [SEL_W-1:0] sel;

    // Strobe index: bit 1 space, bit 0 write.
    always_comb begin
        live = go_nxt && (kind != CY_NONE);
        sel  = {is_io, kind == CY_WRITE};
    end

    for (genvar i = 0; i < N_STROBE; i++) begin : g_strb
        // One strobe register, low only when its index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) strb_n[i] <= 1'b1;
            else        strb_n[i] <= !(live && (sel == SEL_W'(i)));
        end
    end

    // Data enable follows the live strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) den <= 1'b0;
        else        den <= live;
    end

    // Direction set at start and released at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)      dt_r <= 1'b1;
        else if (start)  dt_r <= (kind_nxt != CY_READ);
        else if (finish) dt_r <= 1'b1;
    end
endmodule

// File: rtl/bus_cmd_ctrl.sv
// Top of the local-bus command sequencer. Connects the phase sequencer,
// the command release gate and the output drivers. Assumes all inputs
// are synchronous to clk.
module bus_cmd_ctrl
    import buscmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s1_n,
    input  logic s0_n,
    input  logic io_sel,
    input  logic ready_n,
    input  logic cmd_hold,
    input  logic strap_mb,
    output logic mem_rd_n,
    output logic mem_wr_n,
    output logic io_rd_n,
    output logic io_wr_n,
    output logic den,
    output logic dt_r
);
    bus_ph_t             phase_w;
    cyc_kind_t           kind_w;
    cyc_kind_t           kind_nxt_w;
    logic                is_io_w;
    logic                start_w;
    logic                finish_w;
    logic                go_w;
    logic [N_STROBE-1:0] strb_w;

    buscmd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_n   ({s1_n, s0_n}),
        .io_sel   (io_sel),
        .ready_n  (ready_n),
        .phase    (phase_w),
        .kind     (kind_w),
        .kind_nxt (kind_nxt_w),
        .is_io    (is_io_w),
        .start    (start_w),
        .finish   (finish_w)
    );

    buscmd_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase_w),
        .start    (start_w),
        .finish   (finish_w),
        .cmd_hold (cmd_hold),
        .strap_mb (strap_mb),
        .go_nxt   (go_w)
    );

    buscmd_drv u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_nxt   (go_w),
        .start    (start_w),
        .finish   (finish_w),
        .kind     (kind_w),
        .kind_nxt (kind_nxt_w),
        .is_io    (is_io_w),
        .strb_n   (strb_w),
        .den      (den),
        .dt_r     (dt_r)
    );

    assign mem_rd_n = strb_w[0];
    assign mem_wr_n = strb_w[1];
    assign io_rd_n  = strb_w[2];
    assign io_wr_n  = strb_w[3];
endmodule

// File: rtl/buscmd_chk.sv
// Protocol checker for bus_cmd_ctrl, attached by bind. Observes the
// phase and kind registers and the output pins.
module buscmd_chk
    import buscmd_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      s1_n,
    input logic      s0_n,
    input logic      ready_n,
    input logic      strap_mb,
    input bus_ph_t   phase,
    input cyc_kind_t kind,
    input logic      mem_rd_n,
    input logic      mem_wr_n,
    input logic      io_rd_n,
    input logic      io_wr_n,
    input logic      den,
    input logic      dt_r
);
    logic [3:0] strb_n;
    assign strb_n = {io_wr_n, io_rd_n, mem_wr_n, mem_rd_n};

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~strb_n));

    p_den_with_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        den == !(&strb_n));

    p_stat_to_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_STAT |=> phase == PH_CMD1);

    p_cmd_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_CMD1 |=> phase == PH_CMD2);

    p_wait_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CMD2 && ready_n) |=> phase == PH_CMD1);

    p_read_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && kind == CY_READ) |-> !dt_r);

    p_mode1_holdoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_mb && phase == PH_STAT) |=> (!den && (&strb_n)));

    p_wait_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (den && !(phase == PH_CMD2 && !ready_n)) |=>
        (den && $stable(strb_n) && $stable(dt_r)));

    p_end_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CMD2 && !ready_n) |=> (!den && (&strb_n)));

    p_back_to_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CMD2 && !ready_n && !(s1_n && s0_n)) |=> phase == PH_STAT);
endmodule

bind bus_cmd_ctrl buscmd_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s1_n     (s1_n),
    .s0_n     (s0_n),
    .ready_n  (ready_n),
    .strap_mb (strap_mb),
    .phase    (phase_w),
    .kind     (kind_w),
    .mem_rd_n (mem_rd_n),
    .mem_wr_n (mem_wr_n),
    .io_rd_n  (io_rd_n),
    .io_wr_n  (io_wr_n),
    .den      (den),
    .dt_r     (dt_r)
);

// File: tb/bus_cmd_ctrl_test.sv
`timescale 1ns/100ps
module bus_cmd_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s1_n = 1'b1, s0_n = 1'b1, io_sel = 1'b0, ready_n = 1'b1;
    logic cmd_hold = 1'b0, strap_mb = 1'b0;
    logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, den, dt_r;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    bus_cmd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .s1_n(s1_n), .s0_n(s0_n), .io_sel(io_sel),
        .ready_n(ready_n), .cmd_hold(cmd_hold), .strap_mb(strap_mb),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
        .io_wr_n(io_wr_n), .den(den), .dt_r(dt_r)
    );

    // Vector: {status[1:0], io, mb, hold[2:0], waits[2:0]}
    localparam int NVEC = 10;
    localparam logic [9:0] VEC [NVEC] = '{
        {2'b01, 1'b0, 1'b0, 3'd0, 3'd0},
        {2'b10, 1'b0, 1'b0, 3'd0, 3'd0},
        {2'b01, 1'b1, 1'b0, 3'd0, 3'd1},
        {2'b10, 1'b1, 1'b0, 3'd1, 3'd0},
        {2'b01, 1'b0, 1'b1, 3'd0, 3'd0},
        {2'b10, 1'b1, 1'b1, 3'd3, 3'd1},
        {2'b01, 1'b1, 1'b0, 3'd2, 3'd0},
        {2'b10, 1'b0, 1'b0, 3'd5, 3'd1},
        {2'b00, 1'b0, 1'b0, 3'd0, 3'd0},
        {2'b01, 1'b0, 1'b1, 3'd1, 3'd2}
    };

    function automatic logic [5:0] outs();
        return {io_wr_n, io_rd_n, mem_wr_n, mem_rd_n, den, dt_r};
    endfunction

    task automatic check(input string tag, input logic [5:0] exp);
        logic [5:0] got;
        got = outs();
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b (strobes io_wr,io_rd,mem_wr,mem_rd,den,dt_r)",
                     tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_in();
        {s1_n, s0_n} = 2'b11;
        ready_n  = 1'b1;
        cmd_hold = 1'b0;
    endtask

    localparam logic [5:0] IDLE_OUT = 6'b111101;

    // One full cycle with per-clock expected outputs from the rules.
    task automatic run_cycle(input logic [9:0] v, input int idx);
        logic [1:0] code;
        logic io, mb, act, dir_rd;
        int hold, waits, e, r;
        logic [3:0] es;
        code  = v[9:8];
        io    = v[7];
        mb    = v[6];
        hold  = int'(v[5:3]);
        waits = int'(v[2:0]);
        e = 3 + 2 * waits;
        r = 1 + hold;
        if (mb && r < 2) r = 2;
        strap_mb = mb;
        for (int k = 0; k <= e; k++) begin
            {s1_n, s0_n} = (k == 0) ? code : 2'b11;
            io_sel   = (k == 0) ? io : !io;
            cmd_hold = (k >= 1 && k <= hold);
            ready_n  = (k == e) ? 1'b0 : 1'b1;
            tick();
            act    = (code == 2'b01 || code == 2'b10) && (k >= r) && (k < e);
            dir_rd = (code == 2'b01) && (k < e);
            es     = act ? ~(4'b0001 << {io, code == 2'b10}) : 4'b1111;
            check($sformatf("R3 R4 R5 R6 R7 R8 R9 vec%0d clk%0d", idx, k),
                  {es, act, !dir_rd});
        end
        idle_in();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        idle_in();
        rst_n = 1'b0;
        tick(); tick();
        check("R1 in reset", IDLE_OUT);
        rst_n = 1'b1;
        tick(); tick(); tick();
        check("R1 R2 idle after reset", IDLE_OUT);

        for (int i = 0; i < NVEC; i++) run_cycle(VEC[i], i);

        // R2: status driven mid-cycle is ignored.
        strap_mb = 1'b0;
        {s1_n, s0_n} = 2'b01; io_sel = 1'b0;
        tick();                                  // e0 start read mem
        {s1_n, s0_n} = 2'b10; io_sel = 1'b1;
        tick(); tick(); tick(); tick();          // e1..e4, one wait
        check("R2 status ignored mid-cycle", 6'b111010);
        {s1_n, s0_n} = 2'b11; ready_n = 1'b0;
        tick();                                  // e5 end
        check("R2 R9 end after ignored status", IDLE_OUT);
        idle_in();
        tick();
        check("R2 stays idle", IDLE_OUT);

        // R10: back-to-back read mem then write I/O.
        {s1_n, s0_n} = 2'b01; io_sel = 1'b0;
        tick();                                  // e0
        idle_in();
        tick(); tick();                          // e1, e2
        check("R10 first cycle strobe", 6'b111010);
        {s1_n, s0_n} = 2'b10; io_sel = 1'b1; ready_n = 1'b0;
        tick();                                  // e3 end + new start
        check("R9 R10 release at joint edge", IDLE_OUT);
        idle_in();
        tick();                                  // e4
        check("R10 second cycle strobe no idle", 6'b011111);
        tick();                                  // e5
        ready_n = 1'b0;
        tick();                                  // e6 end
        check("R10 second cycle end", IDLE_OUT);
        idle_in();

        // R1: reset mid-cycle clears outputs.
        {s1_n, s0_n} = 2'b01; io_sel = 1'b1;
        tick();
        idle_in();
        tick();
        check("R1 pre-reset strobe", 6'b101110);
        rst_n = 1'b0;
        tick();
        check("R1 reset mid-cycle", IDLE_OUT);
        rst_n = 1'b1;
        tick(); tick(); tick();
        check("R1 idle after mid reset", IDLE_OUT);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule